// File: doc/BRIEF.md
# Remote DMA Command Engine

The engine moves data between a host-facing streaming data port and a local buffer memory. The host places a remote start address and a remote byte count on plain inputs, picks the transfer width and byte order, then pulses a 3-bit command. A read command fetches from memory and offers each unit on the read stream. A write command accepts units from the write stream and stores each one in memory. Every transfer moves the current address and decrements the remaining count. When the count runs out, a sticky completion flag rises. The host clears that flag by pulsing a clear input.

Both data streams use valid/ready. On the read stream, once `hst_rd_valid` is high it stays high and `hst_rd_data` holds steady until the cycle in which `hst_rd_ready` is seen high. That cycle completes the beat. On the write stream, `hst_wr_ready` is high for as long as a write transfer is running. A beat completes in any cycle in which `hst_wr_valid` and `hst_wr_ready` are both high. The host may hold `hst_wr_valid` low for as long as it likes. The memory is a single synchronous port: read data appears on `mem_rdata` one cycle after an enabled read. The memory places the byte at `mem_addr` on bits [7:0], and for a full-width access the following byte on [15:8].

An abort command stops a transfer at once. The current address stays at the first unit not yet transferred. The current address is always visible as a low byte and a high byte.

Top module: `rdma_engine`

## Requirements
- R1: Command encoding on `cmd` when `cmd_valid` is high: 3'b001 starts a remote read, 3'b010 starts a remote write, and any value with bit 2 set is an abort. 3'b000 and the send-packet code 3'b011 have no effect: busy, the current address, the completion flag and memory stay unchanged.
- R2: During a read, units are offered on `hst_rd_data` in ascending address order, one per handshake. While valid is high and ready is low, valid and data stay unchanged.
- R3: During a write, each accepted unit is written to memory at the current address. The memory port is enabled for writing only in a cycle in which a write handshake takes place.
- R4: With `word_mode`=1 each transfer moves 2 bytes (`mem_word`=1). The address advances by 2 and the count drops by 2, and a final count of 1 still moves one full word. With `word_mode`=0 both change by 1. `word_mode` and `big_endian` are captured when a command starts.
- R5: In word mode with `big_endian`=0, host bits [7:0] are the byte at the lower address. With `big_endian`=1, host bits [15:8] are the byte at the lower address. In byte mode the unit uses host bits [7:0]: reads return 0 in [15:8], and writes ignore [15:8], leaving the next byte of memory untouched.
- R6: The completion flag `done` is high in the cycle after the final handshake, and `busy` is low in that same cycle. A read or write command with a byte count of 0 sets `done` one cycle after the command, with no memory access.
- R7: After an abort, `busy` is low in the next cycle and no further memory access occurs. `done` is not set. The current address keeps the position of the first unit not yet transferred.
- R8: `{cur_addr_hi, cur_addr_lo}` shows the current address at all times. It equals the start address right after a command is accepted, and the start address plus the bytes moved once the transfer completes.
- R9: A pulse on `done_clr` clears `done`. If a completion and a clear fall in the same cycle, `done` ends up set.
- R10: While a transfer is in progress, read and write commands are ignored. Only an abort is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd | input | 3 | Command code |
| start_addr | input | ADDR_W | Remote start address, loaded on read/write command |
| byte_count | input | CNT_W | Remote byte count, loaded on read/write command |
| word_mode | input | 1 | 1 = 2-byte units, 0 = single bytes |
| big_endian | input | 1 | Byte order of a 2-byte unit on the host side |
| done_clr | input | 1 | Clears the completion flag |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | Transfer in progress |
| cur_addr_lo | output | 8 | Current address, low byte |
| cur_addr_hi | output | ADDR_W-8 | Current address, upper bits |
| hst_rd_data | output | DATA_W | Read stream data |
| hst_rd_valid | output | 1 | Read stream valid |
| hst_rd_ready | input | 1 | Read stream ready |
| hst_wr_data | input | DATA_W | Write stream data |
| hst_wr_valid | input | 1 | Write stream valid |
| hst_wr_ready | output | 1 | Write stream ready |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Access width: 1 = full word, 0 = one byte |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data, lower address byte in [7:0] |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |

## Verification
Reads and writes are run in byte mode and in word mode, with both byte orders. On the read side these runs tell a lane swap apart from a correct placement. On the write side they show whether the unused upper byte leaks into memory in byte mode. Some runs stall the read stream and leave gaps in the write stream, which shows whether data is held across back-pressure and whether a beat is counted only on a handshake. An odd count in word mode separates a saturating count from a wrapping one. Zero counts, an abort partway through a read, and commands issued while busy or with the no-op codes test the edges of the command decode and the address-retention rule.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RD_HOLD,
    ST_WR
  } rdma_state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_SEND,
    OP_ABORT
  } rdma_op_e;

endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode
  import rdma_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd,
  output rdma_op_e   op
);

  always_comb begin
    op = OP_NONE;
    if (cmd_valid) begin
      if (cmd[2]) begin
        op = OP_ABORT;
      end else begin
        case (cmd[1:0])
          2'b01:   op = OP_READ;
          2'b10:   op = OP_WRITE;
          2'b11:   op = OP_SEND;
          default: op = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              advance,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              last
);

  localparam logic [CNT_W-1:0] STEP_WIDE = CNT_W'(LANES);
  localparam logic [CNT_W-1:0] STEP_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] step;

  assign step = wide ? STEP_WIDE : STEP_ONE;
  assign last = (cnt <= step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else if (load) begin
      addr <= load_addr;
      cnt  <= load_cnt;
    end else if (advance) begin
      addr <= addr + ADDR_W'(step);
      cnt  <= last ? '0 : (cnt - step);
    end
  end

endmodule

// File: rtl/rdma_lane.sv
module rdma_lane #(
  parameter int DATA_W = 16
) (
  input  logic              wide,
  input  logic              swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] reversed;

  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign reversed[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
  end

  always_comb begin
    if (wide) begin
      dout = swap ? reversed : din;
    end else begin
      dout = '0;
      dout[7:0] = din[7:0];
    end
  end

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              word_mode,
  input  logic              big_endian,
  input  logic              done_clr,
  output logic              done,
  output logic              busy,
  output logic [7:0]        cur_addr_lo,
  output logic [ADDR_W-9:0] cur_addr_hi,
  output logic [DATA_W-1:0] hst_rd_data,
  output logic              hst_rd_valid,
  input  logic              hst_rd_ready,
  input  logic [DATA_W-1:0] hst_wr_data,
  input  logic              hst_wr_valid,
  output logic              hst_wr_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int LANES = DATA_W / 8;

  rdma_state_e       state_q, state_d;
  rdma_op_e          op;
  logic              wide_q, swap_q;
  logic              done_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_lane;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic              abort_now, start_rd, start_wr, load;
  logic              zero_cmd, rd_hs, wr_hs, advance, finish;

  rdma_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .op        (op)
  );

  assign abort_now = (op == OP_ABORT);
  assign start_rd  = (op == OP_READ)  && (state_q == ST_IDLE);
  assign start_wr  = (op == OP_WRITE) && (state_q == ST_IDLE);
  assign load      = start_rd || start_wr;
  assign zero_cmd  = load && (byte_count == '0);

  assign rd_hs   = (state_q == ST_RD_HOLD) && hst_rd_ready;
  assign wr_hs   = (state_q == ST_WR) && hst_wr_valid;
  assign advance = (rd_hs || wr_hs) && !abort_now;
  assign finish  = advance && last;

  rdma_ptr #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (start_addr),
    .load_cnt  (byte_count),
    .advance   (advance),
    .wide      (wide_q),
    .addr      (addr),
    .cnt       (cnt),
    .last      (last)
  );

  rdma_lane #(.DATA_W(DATA_W)) u_rd_lane (
    .wide (wide_q),
    .swap (swap_q),
    .din  (mem_rdata),
    .dout (rd_lane)
  );

  rdma_lane #(.DATA_W(DATA_W)) u_wr_lane (
    .wide (wide_q),
    .swap (swap_q),
    .din  (hst_wr_data),
    .dout (mem_wdata)
  );

  always_comb begin
    state_d = state_q;
    if (abort_now) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_rd && !zero_cmd)      state_d = ST_RD_REQ;
          else if (start_wr && !zero_cmd) state_d = ST_WR;
        end
        ST_RD_REQ:  state_d = ST_RD_WAIT;
        ST_RD_WAIT: state_d = ST_RD_HOLD;
        ST_RD_HOLD: begin
          if (hst_rd_ready) state_d = last ? ST_IDLE : ST_RD_REQ;
        end
        ST_WR: begin
          if (hst_wr_valid && last) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wide_q  <= 1'b0;
      swap_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        wide_q <= word_mode;
        swap_q <= big_endian;
      end
      if (finish || zero_cmd) begin
        done_q <= 1'b1;
      end else if (done_clr) begin
        done_q <= 1'b0;
      end
      if (state_q == ST_RD_WAIT) begin
        rd_q <= rd_lane;
      end
    end
  end

  assign done         = done_q;
  assign busy         = (state_q != ST_IDLE);
  assign cur_addr_lo  = addr[7:0];
  assign cur_addr_hi  = addr[ADDR_W-1:8];
  assign hst_rd_data  = rd_q;
  assign hst_rd_valid = (state_q == ST_RD_HOLD);
  assign hst_wr_ready = (state_q == ST_WR) && !abort_now;
  assign mem_en       = ((state_q == ST_RD_REQ) || wr_hs) && !abort_now;
  assign mem_we       = (state_q == ST_WR);
  assign mem_word     = wide_q;
  assign mem_addr     = addr;

endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd,
  input logic              done,
  input logic              busy,
  input logic [7:0]        cur_addr_lo,
  input logic [ADDR_W-9:0] cur_addr_hi,
  input logic [DATA_W-1:0] hst_rd_data,
  input logic              hst_rd_valid,
  input logic              hst_rd_ready,
  input logic              hst_wr_valid,
  input logic              hst_wr_ready,
  input logic              mem_en,
  input logic              mem_we,
  input logic              mem_word
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] cur_addr;
  logic              abort_now, any_hs;

  assign cur_addr  = {cur_addr_hi, cur_addr_lo};
  assign abort_now = cmd_valid && cmd[2];
  assign any_hs    = (hst_rd_valid && hst_rd_ready) || (hst_wr_valid && hst_wr_ready);

  p_ignore_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd == 3'b000 || cmd == 3'b011)) |=> !busy);

  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd_valid && !hst_rd_ready && !abort_now) |=> (hst_rd_valid && $stable(hst_rd_data)));

  p_wr_on_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (hst_wr_valid && hst_wr_ready));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hs && !abort_now) |=>
      (cur_addr == $past(cur_addr) + ($past(mem_word) ? ADDR_W'(LANES) : ADDR_W'(1))));

  p_done_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || $past(abort_now)));

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> (!busy && !mem_en));

  p_abort_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> $stable(cur_addr));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd          (cmd),
  .done         (done),
  .busy         (busy),
  .cur_addr_lo  (cur_addr_lo),
  .cur_addr_hi  (cur_addr_hi),
  .hst_rd_data  (hst_rd_data),
  .hst_rd_valid (hst_rd_valid),
  .hst_rd_ready (hst_rd_ready),
  .hst_wr_valid (hst_wr_valid),
  .hst_wr_ready (hst_wr_ready),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_word     (mem_word)
);

// File: tb/sim_rdma_engine.sv
module sim_rdma_engine;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cmd_valid, word_mode, big_endian, done_clr;
  logic [2:0]  cmd;
  logic [15:0] start_addr, byte_count;
  logic        done, busy, hst_rd_valid, hst_rd_ready, hst_wr_valid, hst_wr_ready;
  logic [7:0]  cur_addr_lo, cur_addr_hi;
  logic [15:0] hst_rd_data, hst_wr_data;
  logic        mem_en, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  rdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .start_addr(start_addr), .byte_count(byte_count), .word_mode(word_mode),
    .big_endian(big_endian), .done_clr(done_clr), .done(done), .busy(busy),
    .cur_addr_lo(cur_addr_lo), .cur_addr_hi(cur_addr_hi),
    .hst_rd_data(hst_rd_data), .hst_rd_valid(hst_rd_valid), .hst_rd_ready(hst_rd_ready),
    .hst_wr_data(hst_wr_data), .hst_wr_valid(hst_wr_valid), .hst_wr_ready(hst_wr_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [0:511];
  logic [7:0] ref_mem [0:511];
  int n_chk = 0, n_fail = 0, mem_acc = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7) ^ 8'h3C;
  endfunction

  function automatic logic [8:0] ix(input logic [15:0] a, input int off);
    return 9'(a + 16'(off));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      mem_acc <= mem_acc + 1;
      if (mem_we) begin
        mem[ix(mem_addr, 0)] <= mem_wdata[7:0];
        if (mem_word) mem[ix(mem_addr, 1)] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= mem_word ? {mem[ix(mem_addr, 1)], mem[ix(mem_addr, 0)]}
                              : {8'h00, mem[ix(mem_addr, 0)]};
      end
    end
  end

  function automatic logic [15:0] cur();
    return {cur_addr_hi, cur_addr_lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [15:0] a, input logic [15:0] n,
                       input logic w, input logic be);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; start_addr = a; byte_count = n;
    word_mode = w; big_endian = be;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R9 done cleared by pulse", done, 0);
  endtask

  task automatic wait_rd();
    for (int t = 0; t < 50 && !hst_rd_valid; t++) @(negedge clk);
  endtask

  task automatic wait_wr();
    for (int t = 0; t < 50 && !hst_wr_ready; t++) @(negedge clk);
  endtask

  task automatic read_beats(input logic [15:0] a0, input int beats, input logic w,
                            input logic be, input logic stall);
    logic [15:0] a, exp;
    a = a0;
    for (int b = 0; b < beats; b++) begin
      wait_rd();
      exp = w ? (be ? {ref_mem[ix(a, 0)], ref_mem[ix(a, 1)]}
                    : {ref_mem[ix(a, 1)], ref_mem[ix(a, 0)]})
              : {8'h00, ref_mem[ix(a, 0)]};
      chk("R2 R5 read data", hst_rd_data, exp);
      if (stall) begin
        @(negedge clk);
        chk("R2 valid held under stall", hst_rd_valid, 1);
        chk("R2 data held under stall", hst_rd_data, exp);
      end
      hst_rd_ready = 1'b1;
      @(negedge clk);
      hst_rd_ready = 1'b0;
      a = a + (w ? 16'd2 : 16'd1);
    end
  endtask

  task automatic write_beats(input logic [15:0] a0, input int beats, input logic w,
                             input logic be, input logic stall);
    logic [15:0] a, d;
    a = a0;
    for (int b = 0; b < beats; b++) begin
      if (stall && b == 1) @(negedge clk);
      wait_wr();
      d = 16'hA000 ^ 16'(b * 16'h0111) ^ a0;
      hst_wr_valid = 1'b1; hst_wr_data = d;
      if (!w) ref_mem[ix(a, 0)] = d[7:0];
      else if (be) begin ref_mem[ix(a, 0)] = d[15:8]; ref_mem[ix(a, 1)] = d[7:0]; end
      else begin ref_mem[ix(a, 0)] = d[7:0]; ref_mem[ix(a, 1)] = d[15:8]; end
      @(negedge clk);
      hst_wr_valid = 1'b0;
      a = a + (w ? 16'd2 : 16'd1);
    end
  endtask

  task automatic check_mem(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  typedef struct packed {
    logic        is_wr;
    logic [15:0] start;
    logic [15:0] count;
    logic        word;
    logic        be;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 16'd16,  16'd5, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd32,  16'd8, 1'b1, 1'b0, 1'b0},
    '{1'b0, 16'd64,  16'd6, 1'b1, 1'b1, 1'b1},
    '{1'b0, 16'd40,  16'd5, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd100, 16'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'd130, 16'd6, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'd200, 16'd4, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int acc;
    logic [15:0] keep;
    for (int i = 0; i < 512; i++) ref_mem[i] = pat(i);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = 3'b000; start_addr = '0; byte_count = '0;
    word_mode = 1'b0; big_endian = 1'b0; done_clr = 1'b0;
    hst_rd_ready = 1'b0; hst_wr_valid = 1'b0; hst_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset done low", done, 0);
    chk("R7 reset idle", busy, 0);
    chk("R8 reset address", cur(), 0);
    chk("R2 reset read valid low", hst_rd_valid, 0);

    // table-driven transfers: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 7; v++) begin
      int step, beats;
      step  = VECS[v].word ? 2 : 1;
      beats = (int'(VECS[v].count) + step - 1) / step;
      issue(VECS[v].is_wr ? 3'b010 : 3'b001, VECS[v].start, VECS[v].count,
            VECS[v].word, VECS[v].be);
      chk("R8 address loaded at start", cur(), VECS[v].start);
      if (VECS[v].is_wr) write_beats(VECS[v].start, beats, VECS[v].word, VECS[v].be, VECS[v].stall);
      else               read_beats(VECS[v].start, beats, VECS[v].word, VECS[v].be, VECS[v].stall);
      chk("R6 done after final beat", done, 1);
      chk("R6 idle after final beat", busy, 0);
      chk("R4 R8 final address", cur(), VECS[v].start + 16'(beats * step));
      if (VECS[v].is_wr) check_mem("R3 R5 memory after write");
      clear_done();
    end

    // R6: zero byte count completes at once, no memory access
    acc = mem_acc;
    issue(3'b001, 16'd77, 16'd0, 1'b0, 1'b0);
    chk("R6 zero count done", done, 1);
    chk("R6 zero count idle", busy, 0);
    chk("R8 zero count address", cur(), 77);
    chk("R6 zero count no access", mem_acc, acc);

    // R9: completion and clear in the same cycle -> set wins
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'b010; start_addr = 16'd88; byte_count = 16'd0; done_clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; done_clr = 1'b0;
    chk("R9 set wins over clear", done, 1);
    clear_done();

    // R1: codes 000 and 011 have no effect
    keep = cur();
    acc = mem_acc;
    issue(3'b000, 16'd50, 16'd3, 1'b0, 1'b0);
    chk("R1 code 000 stays idle", busy, 0);
    issue(3'b011, 16'd60, 16'd4, 1'b1, 1'b0);
    chk("R1 code 011 stays idle", busy, 0);
    repeat (3) @(negedge clk);
    chk("R1 no-op codes keep address", cur(), keep);
    chk("R1 no-op codes keep done", done, 0);
    chk("R1 no-op codes no access", mem_acc, acc);

    // R7: abort partway through a word read
    issue(3'b001, 16'd300, 16'd8, 1'b1, 1'b0);
    read_beats(16'd300, 2, 1'b1, 1'b0, 1'b0);
    wait_rd();
    cmd_valid = 1'b1; cmd = 3'b110;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 abort leaves busy low", busy, 0);
    chk("R7 abort drops read valid", hst_rd_valid, 0);
    chk("R7 abort does not set done", done, 0);
    chk("R7 abort keeps stopped address", cur(), 304);
    acc = mem_acc;
    repeat (5) @(negedge clk);
    chk("R7 no access after abort", mem_acc, acc);
    chk("R7 address still held", cur(), 304);

    // R10: read command while a write runs is ignored
    issue(3'b010, 16'd400, 16'd4, 1'b1, 1'b0);
    issue(3'b001, 16'd16, 16'd2, 1'b0, 1'b0);
    chk("R10 address not reloaded", cur(), 400);
    chk("R10 still busy", busy, 1);
    chk("R10 still in write", hst_wr_ready, 1);
    write_beats(16'd400, 2, 1'b1, 1'b0, 1'b0);
    chk("R10 write completes", done, 1);
    chk("R10 final address", cur(), 404);
    check_mem("R10 R3 memory after write");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule